// File: doc/BRIEF.md
# Quadrature Position Counter with Registration Latches

This block turns the channel A, channel B and once-per-revolution marker signals of an incremental shaft encoder into a 16-bit position count. Each encoder pin and marker pin goes through a two-stage synchronizer and a digital glitch filter whose length software sets. The decoder counts on every edge of A and B (x4 decode). A second mode reads A as a count clock and B as a direction level. The count wraps between zero and a programmable top value.

Two registration inputs copy the live count into two separate capture registers and raise sticky flags. A missed service raises an overrun flag. Software can let the marker clear the counter on every marker, or only on the first marker after it arms the block. A consistency monitor compares the count at each marker with the count at the marker before it. It also flags a sample in which A and B change together. A free-running loop timer, independent of the encoder, raises a periodic flag. Every flag feeds one interrupt line and is cleared by writing a one to it.

Register map (3-bit address, reads are combinational): 0 control (bit0 clock/direction mode, bit1 marker clear enable, bit2 first-marker-only mode, bit3 armed, bits 11:8 filter length L); 1 top count; 2 position (read/write); 3 capture 0; 4 capture 1; 5 status (bit0 capture 0 flag, bit1 capture 1 flag, bit2 capture 0 overrun, bit3 capture 1 overrun, bit4 count error, bit5 loop-timer flag); 6 loop-timer period; 7 reads zero.

Top module: `qenc_top`

## Requirements
- R1: In quadrature mode every accepted edge of A or B moves the position by one. The sequence (A,B) = 00, 10, 11, 01 counts up and the reverse sequence counts down.
- R2: Counting up from the top count gives 0, and counting down from 0 gives the top count. The top count resets to 16'hFFFF.
- R3: A pin level is accepted only after the synchronized input has differed from the accepted level on L+1 consecutive clocks (L = control bits 11:8). A shorter pulse leaves the position unchanged.
- R4: With control bit0 set, each rising edge of A counts up when B is 1 and down when B is 0. Falling edges of A and changes of B leave the position unchanged.
- R5: A rising edge on registration input 0 (or 1) copies the position into capture 0 (or 1) and sets status bit0 (or bit1).
- R6: A capture that arrives while its flag is still set sets the overrun bit (status bit2 for input 0, bit3 for input 1) and still updates the capture register.
- R7: With control bit1 set and bit2 clear, every rising marker edge clears the position to 0.
- R8: With control bits 1 and 2 set, a marker edge clears the position only while the armed bit (control bit3, set by writing 1) is set, and that clear drops the armed bit. Later markers leave the position unchanged.
- R9: Status bit4 is set when the position at a marker edge differs from the position at the previous marker edge (the first marker after reset only records). It is also set when A and B change in the same sample in quadrature mode, and that sample does not count.
- R10: With a nonzero period P, status bit5 is set once every P+1 clocks, whatever the encoder does. With P = 0 it is never set.
- R11: The interrupt output is high exactly while any status bit is set. Writing 1 to a status bit clears it, and a hardware set in the same cycle wins.
- R12: After reset the position, both captures, the status and the control are 0, and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| encA | input | 1 | Encoder channel A, or count clock in clock/direction mode |
| encB | input | 1 | Encoder channel B, or direction level |
| encZ | input | 1 | Once-per-revolution marker |
| regIn0 | input | 1 | Registration input 0 |
| regIn1 | input | 1 | Registration input 1 |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wrData | input | 16 | Register write data |
| rdData | output | 16 | Register read data for addr |
| irq | output | 1 | Interrupt, OR of all status bits |

## Verification
A pin change reaches the position after two synchronizer flops, L+1 filter samples and the count register, so it appears L+4 clocks later. The bench waits L+6 clocks after every pin move before it reads a register. Status flags from captures, markers and errors follow the same path. The loop-timer flag is polled every clock, and the spacing between two consecutive sets must be exactly P+1 clock counts. Register writes take effect at the next edge, and all reads are taken a little after the falling edge.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_TOP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_POS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP0 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAP1 = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;
  localparam logic [ADDR_W-1:0] A_PER  = 3'd6;
  localparam int STAT_W = 6;

  typedef struct packed {
    logic cntUp;
    logic cntDn;
    logic markerHit;
    logic markerRst;
    logic illegal;
    logic cap0;
    logic cap1;
  } qencStrobe_t;
endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pinIn,
  input  logic [LEN_W-1:0] filtLen,
  output logic             levelOut
);
  logic syncA, syncB, level;
  logic [LEN_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= 1'b0;
      syncB  <= 1'b0;
      level  <= 1'b0;
      runCnt <= '0;
    end else begin
      syncA <= pinIn;
      syncB <= syncA;
      if (syncB == level) begin
        runCnt <= '0;
      end else if (runCnt == filtLen) begin
        level  <= syncB;
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign levelOut = level;
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        fltA,
  input  logic        fltB,
  input  logic        fltZ,
  input  logic        fltR0,
  input  logic        fltR1,
  input  logic        freqDir,
  input  logic        mrkRstEn,
  input  logic        singleMrk,
  input  logic        armed,
  output qencStrobe_t stb
);
  logic prevA, prevB, prevZ, prevR0, prevR1;
  logic chgA, chgB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA  <= 1'b0;
      prevB  <= 1'b0;
      prevZ  <= 1'b0;
      prevR0 <= 1'b0;
      prevR1 <= 1'b0;
    end else begin
      prevA  <= fltA;
      prevB  <= fltB;
      prevZ  <= fltZ;
      prevR0 <= fltR0;
      prevR1 <= fltR1;
    end
  end

  assign chgA = fltA ^ prevA;
  assign chgB = fltB ^ prevB;

  always_comb begin
    stb = '0;
    if (freqDir) begin
      stb.cntUp = fltA & ~prevA & fltB;
      stb.cntDn = fltA & ~prevA & ~fltB;
    end else begin
      stb.cntUp   = (chgA ^ chgB) & (fltA ^ prevB);
      stb.cntDn   = (chgA ^ chgB) & ~(fltA ^ prevB);
      stb.illegal = chgA & chgB;
    end
    stb.markerHit = fltZ & ~prevZ;
    stb.markerRst = stb.markerHit & mrkRstEn & (~singleMrk | armed);
    stb.cap0      = fltR0 & ~prevR0;
    stb.cap1      = fltR1 & ~prevR1;
  end
endmodule

// File: rtl/qenc_datapath.sv
module qenc_datapath
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 4,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  qencStrobe_t       stb,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              freqDir,
  output logic              mrkRstEn,
  output logic              singleMrk,
  output logic              armed,
  output logic [LEN_W-1:0]  filtLen,
  output logic              irq
);
  localparam int LEN_LSB = 8;

  logic [CNT_W-1:0]  topQ, posQ, cap0Q, cap1Q, markPos;
  logic [STAT_W-1:0] statusQ, statSet, statClr;
  logic [TMR_W-1:0]  periodQ, tmrCnt;
  logic              markValid, tick, cntErr;
  logic              wrCtrl, wrPos, wrStat;

  assign wrCtrl = wrEn && (addr == A_CTRL);
  assign wrPos  = wrEn && (addr == A_POS);
  assign wrStat = wrEn && (addr == A_STAT);

  assign tick   = (periodQ != '0) && (tmrCnt == periodQ);
  assign cntErr = stb.illegal | (stb.markerHit & markValid & (posQ != markPos));

  always_comb begin
    statSet = {tick, cntErr, stb.cap1 & statusQ[1], stb.cap0 & statusQ[0],
               stb.cap1, stb.cap0};
    statClr = wrStat ? wrData[STAT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freqDir   <= 1'b0;
      mrkRstEn  <= 1'b0;
      singleMrk <= 1'b0;
      armed     <= 1'b0;
      filtLen   <= '0;
      topQ      <= '1;
      posQ      <= '0;
      cap0Q     <= '0;
      cap1Q     <= '0;
      markPos   <= '0;
      markValid <= 1'b0;
      statusQ   <= '0;
      periodQ   <= '0;
      tmrCnt    <= '0;
    end else begin
      if (wrCtrl) begin
        freqDir   <= wrData[0];
        mrkRstEn  <= wrData[1];
        singleMrk <= wrData[2];
        armed     <= wrData[3];
        filtLen   <= wrData[LEN_LSB +: LEN_W];
      end else if (stb.markerRst && singleMrk) begin
        armed <= 1'b0;
      end
      if (wrEn && addr == A_TOP) topQ    <= wrData;
      if (wrEn && addr == A_PER) periodQ <= wrData[TMR_W-1:0];

      if (wrPos)              posQ <= wrData;
      else if (stb.markerRst) posQ <= '0;
      else if (stb.cntUp)     posQ <= (posQ == topQ) ? '0 : posQ + 1'b1;
      else if (stb.cntDn)     posQ <= (posQ == '0) ? topQ : posQ - 1'b1;

      if (stb.cap0) cap0Q <= posQ;
      if (stb.cap1) cap1Q <= posQ;
      if (stb.markerHit) begin
        markPos   <= posQ;
        markValid <= 1'b1;
      end

      statusQ <= (statusQ & ~statClr) | statSet;

      if (periodQ == '0 || tmrCnt >= periodQ) tmrCnt <= '0;
      else                                    tmrCnt <= tmrCnt + 1'b1;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_CTRL: begin
        rdData[3:0] = {armed, singleMrk, mrkRstEn, freqDir};
        rdData[LEN_LSB +: LEN_W] = filtLen;
      end
      A_TOP:  rdData = topQ;
      A_POS:  rdData = posQ;
      A_CAP0: rdData = cap0Q;
      A_CAP1: rdData = cap1Q;
      A_STAT: rdData[STAT_W-1:0] = statusQ;
      A_PER:  rdData[TMR_W-1:0] = periodQ;
      default: rdData = '0;
    endcase
  end

  assign irq = |statusQ;
endmodule

// File: rtl/qenc_top.sv
module qenc_top
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LEN_W = 4,
  parameter int TMR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              encA,
  input  logic              encB,
  input  logic              encZ,
  input  logic              regIn0,
  input  logic              regIn1,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              irq
);
  localparam int N_PIN   = 5;
  localparam int N_FILT  = 3;

  logic [N_PIN-1:0] pinRaw, pinFlt;
  logic [LEN_W-1:0] filtLen;
  logic             freqDir, mrkRstEn, singleMrk, armed;
  qencStrobe_t      stb;

  assign pinRaw = {regIn1, regIn0, encZ, encB, encA};

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    qenc_filter #(.LEN_W(LEN_W)) u_filt (
      .clk      (clk),
      .rstN     (rstN),
      .pinIn    (pinRaw[i]),
      .filtLen  ((i < N_FILT) ? filtLen : '0),
      .levelOut (pinFlt[i])
    );
  end

  qenc_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .fltA      (pinFlt[0]),
    .fltB      (pinFlt[1]),
    .fltZ      (pinFlt[2]),
    .fltR0     (pinFlt[3]),
    .fltR1     (pinFlt[4]),
    .freqDir   (freqDir),
    .mrkRstEn  (mrkRstEn),
    .singleMrk (singleMrk),
    .armed     (armed),
    .stb       (stb)
  );

  qenc_datapath #(.CNT_W(CNT_W), .LEN_W(LEN_W), .TMR_W(TMR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wrEn      (wrEn),
    .addr      (addr),
    .wrData    (wrData),
    .rdData    (rdData),
    .freqDir   (freqDir),
    .mrkRstEn  (mrkRstEn),
    .singleMrk (singleMrk),
    .armed     (armed),
    .filtLen   (filtLen),
    .irq       (irq)
  );
endmodule

// File: rtl/qenc_chk.sv
module qenc_chk
  import qenc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input qencStrobe_t       stb,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  posQ,
  input logic [CNT_W-1:0]  topQ,
  input logic [STAT_W-1:0] statusQ,
  input logic              armed,
  input logic              singleMrk,
  input logic              mrkRstEn
);
  logic posFree;
  assign posFree = !(wrEn && addr == A_POS) && !stb.markerRst;

  // R1
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.cntUp, stb.cntDn}));

  // R2
  wrap_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntUp && posFree && posQ == topQ) |=> posQ == '0);

  // R2
  wrap_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cntDn && posFree && posQ == '0) |=> posQ == $past(topQ));

  // R5
  cap_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.cap0 |=> statusQ[0]);

  // R6
  overrun_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.cap1 && statusQ[1]) |=> statusQ[3]);

  // R9
  illegal_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.illegal |=> statusQ[4]);

  // R8
  arm_use_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markerRst && singleMrk && !(wrEn && addr == A_CTRL)) |=> !armed);

  // R8
  unarmed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.markerHit && mrkRstEn && singleMrk && !armed) |-> !stb.markerRst);
endmodule

bind qenc_top qenc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .stb       (stb),
  .wrEn      (wrEn),
  .addr      (addr),
  .posQ      (u_dp.posQ),
  .topQ      (u_dp.topQ),
  .statusQ   (u_dp.statusQ),
  .armed     (armed),
  .singleMrk (singleMrk),
  .mrkRstEn  (mrkRstEn)
);

// File: tb/qenc_top_tb.sv
module qenc_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic encA = 1'b0, encB = 1'b0, encZ = 1'b0, regIn0 = 1'b0, regIn1 = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [15:0] wrData = 16'd0;
  logic [15:0] rdData;
  logic irq;

  int checks = 0, failures = 0, cyc = 0, idx = 0, flen = 0;
  bit done = 0;
  logic [15:0] v;

  qenc_top u_dut (.clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encZ(encZ),
    .regIn0(regIn0), .regIn1(regIn1), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic settle();
    repeat (flen + 6) @(negedge clk);
  endtask

  task automatic setPins();
    encA = (idx == 1 || idx == 2);
    encB = (idx == 2 || idx == 3);
    settle();
  endtask

  task automatic step(input bit up);
    idx = up ? (idx + 1) % 4 : (idx + 3) % 4;
    setPins();
  endtask

  task automatic expPos(input int e, input string req);
    rd(3'd2, v);
    chk(v == e[15:0], req, v, e);
  endtask

  task automatic pulseZ();
    encZ = 1'b1; settle(); encZ = 1'b0; settle();
  endtask

  task automatic pulseA();
    encA = 1'b0; settle(); encA = 1'b1; settle();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int t1, t2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R12 reset state
    expPos(0, "R12 pos");
    rd(3'd5, v); chk(v == 0, "R12 status", v, 0);
    rd(3'd0, v); chk(v == 0, "R12 ctrl", v, 0);
    rd(3'd1, v); chk(v == 16'hFFFF, "R12/R2 top", v, 16'hFFFF);
    #1 chk(irq == 0, "R12 irq", irq, 0);

    // R1 forward and reverse x4 counting, R2 wrap at default top
    for (int i = 1; i <= 5; i++) begin step(1); expPos(i, "R1 up"); end
    for (int i = 1; i <= 7; i++) begin
      step(0);
      expPos((5 - i + 65536) % 65536, "R1/R2 down");
    end
    // R2 programmable top
    wr(3'd1, 16'd9); wr(3'd2, 16'd8);
    step(1); expPos(9, "R2 up to top");
    step(1); expPos(0, "R2 wrap up");
    step(0); expPos(9, "R2 wrap down");
    step(0); expPos(8, "R2 down from top");

    // R3 filter length 4: a 4-clock pulse is rejected, a held change counts
    wr(3'd0, 16'h0400); flen = 4;
    encA = ~encA; repeat (4) @(negedge clk); encA = ~encA; settle();
    expPos(8, "R3 short pulse ignored");
    step(1); expPos(9, "R3 held level accepted");
    wr(3'd0, 16'h0000); flen = 0;

    // R9 illegal double change
    wr(3'd2, 16'd3);
    idx = (idx + 2) % 4; setPins();
    expPos(3, "R9 no count on double change");
    rd(3'd5, v); chk(v[4] == 1, "R9 illegal flag", v, 16'h10);
    #1 chk(irq == 1, "R11 irq set", irq, 1);
    wr(3'd5, 16'h003F);
    rd(3'd5, v); chk(v == 0, "R11 clear", v, 0);
    #1 chk(irq == 0, "R11 irq clear", irq, 0);

    // R4 clock/direction mode
    idx = 2; setPins();
    wr(3'd0, 16'h0001); wr(3'd2, 16'd2);
    for (int i = 0; i < 3; i++) pulseA();
    expPos(5, "R4 up with B=1");
    encB = 1'b0; settle();
    expPos(5, "R4 B change ignored");
    encA = 1'b0; settle();
    expPos(5, "R4 falling A ignored");
    encA = 1'b1; settle();
    pulseA();
    expPos(3, "R4 down with B=0");
    wr(3'd0, 16'h0000); idx = 1;

    // R5/R6 registration
    wr(3'd2, 16'd7);
    regIn0 = 1'b1; settle(); regIn0 = 1'b0; settle();
    rd(3'd3, v); chk(v == 7, "R5 capture 0", v, 7);
    rd(3'd5, v); chk(v == 16'h1, "R5 flag 0", v, 1);
    step(1);
    regIn1 = 1'b1; settle(); regIn1 = 1'b0; settle();
    rd(3'd4, v); chk(v == 8, "R5 capture 1", v, 8);
    regIn0 = 1'b1; settle(); regIn0 = 1'b0; settle();
    rd(3'd3, v); chk(v == 8, "R6 capture 0 updated", v, 8);
    rd(3'd5, v); chk(v == 16'h7, "R6 overrun 0", v, 7);
    regIn1 = 1'b1; settle(); regIn1 = 1'b0; settle();
    rd(3'd5, v); chk(v == 16'hF, "R6 overrun 1", v, 16'hF);
    wr(3'd5, 16'h003F);

    // R9 marker consistency
    wr(3'd2, 16'd3);
    pulseZ(); rd(3'd5, v); chk(v[4] == 0, "R9 first marker", v, 0);
    pulseZ(); rd(3'd5, v); chk(v[4] == 0, "R9 same count", v, 0);
    step(1);
    pulseZ(); rd(3'd5, v); chk(v[4] == 1, "R9 mismatch", v, 16'h10);
    wr(3'd5, 16'h003F);

    // R7 marker clear on every marker
    wr(3'd0, 16'h0002); wr(3'd2, 16'd5);
    pulseZ(); expPos(0, "R7 clear");
    step(1); step(1); expPos(2, "R7 count after clear");
    pulseZ(); expPos(0, "R7 clear again");

    // R8 first marker only
    wr(3'd0, 16'h0006); wr(3'd2, 16'd6);
    pulseZ(); expPos(6, "R8 unarmed ignored");
    wr(3'd0, 16'h000E);
    rd(3'd0, v); chk(v[3] == 1, "R8 armed", v, 16'hE);
    pulseZ(); expPos(0, "R8 armed clear");
    rd(3'd0, v); chk(v[3] == 0, "R8 disarmed", v, 6);
    wr(3'd2, 16'd4);
    pulseZ(); expPos(4, "R8 later marker ignored");
    wr(3'd0, 16'h0000); wr(3'd5, 16'h003F);

    // R10 loop timer period 9 -> every 10 clocks
    wr(3'd6, 16'd9); wr(3'd5, 16'h003F);
    t1 = -1; t2 = -1;
    for (int i = 0; i < 40 && t1 < 0; i++) begin rd(3'd5, v); if (v[5]) t1 = cyc; end
    wr(3'd5, 16'h0020);
    for (int i = 0; i < 40 && t2 < 0; i++) begin rd(3'd5, v); if (v[5]) t2 = cyc; end
    chk(t1 >= 0 && t2 - t1 == 10, "R10 interval", t2 - t1, 10);
    wr(3'd6, 16'd0); wr(3'd5, 16'h003F);
    repeat (40) @(negedge clk);
    rd(3'd5, v); chk(v == 0, "R10 stopped", v, 0);
    #1 chk(irq == 0, "R11 irq idle", irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule